// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable slave model of a small serial EEPROM with a chip select, a serial clock, a data input and a data output. The three input pins are oversampled in the system-clock domain. The data output comes with a separate drive-enable, so the pad can be tri-stated. The stored words sit in a register array that resets to the erased state, which is all ones. A static strap selects either 16-bit words or 8-bit words. With 8-bit words the address gains one bit.

A host lowers and raises the select line and shifts commands in on rising serial-clock edges. Each command is a start bit, a two-bit opcode, an address and, for writes, a data word. Reads return a dummy zero and then the data, most significant bit first. The data keeps streaming from successive addresses while the select stays high.

Any change to the array is held back until the select falls after a complete command. The change is then applied at the end of a self-timed program cycle, whose length is set by a parameter. While that cycle runs, raising the select shows busy or ready on the output.

Top module: `sereep_model`

## Requirements
- R1: Before a start condition, which is a serial-clock rise with select high and data-in high, no command is taken. Clock rises with data-in low, and any clocking while select is low, leave the output undriven and do not disturb a following command in the same select period.
- R2: With `org_wide_i`=1, words are 16 bits and the address is ADDR_W16 bits. With it at 0, the address is ADDR_W16+1 bits and selects a byte: byte address b maps to word b>>1, and b[0]=0 selects bits 7:0 while b[0]=1 selects bits 15:8.
- R3: Opcode 10 is a read. After the last address bit, the output drives a 0. Each following serial-clock rise then presents the next data bit, most significant first.
- R4: While select stays high after a word has been read, the address increments and the next word follows with no dummy bit. The address wraps from the last location to 0.
- R5: After reset, programming is disabled. Opcodes 01 (write) and 11 (erase), erase-all and write-all then change nothing. A read works whether programming is enabled or not.
- R6: Opcode 00 takes its sub-code from the two top address bits. Sub-code 11 enables programming and sub-code 00 disables it. The setting holds until changed or until reset.
- R7: Erase sets the addressed word or byte to all ones. Write replaces it with the shifted-in data and leaves the rest of the array untouched.
- R8: Sub-code 10 sets every location to all ones. Sub-code 01, followed by one data word, writes that word to every location.
- R9: A program cycle starts only when the select falls after every required bit of the command has been received. A command cut short changes nothing and starts no cycle.
- R10: After a program cycle has started, raising the select drives the output to 0 while the cycle runs and to 1 when it is done. The output enable is 0 whenever the select is low and is 0 after reset.
- R11: A single-location cycle lasts PROG_CYCLES system clocks and an all-location cycle lasts 2*PROG_CYCLES. Start conditions are ignored while a cycle is running.
- R12: If a select fall and a serial-clock rise are seen in the same system clock, the fall wins and that clock edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_wide_i | input | 1 | Organization strap: 1 = 16-bit words, 0 = 8-bit words |
| cs_i | input | 1 | Chip select pin, active high |
| sck_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data input pin |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Drive enable for sdo_o (0 = high impedance) |

## Verification
The key coincidence is a select fall and a serial-clock rise arriving in the same system clock. The fall can launch a program cycle, and the clock rise can supply the last bit that the command still needs. The bench provokes this by moving both pins at the same instant on the final data bit of a write. It then judges the outcome only at the ports: the addressed word must read back unchanged, and raising the select again must leave the output undriven, because no cycle was started. A second overlap, a start condition sent while a program cycle is still running, is judged by the output staying at the busy value through a full word of clocks.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA,
      ST_READ,
      ST_DONE
   } ctl_state_t;

   typedef enum logic [1:0] {
      PG_NONE,
      PG_WORD,
      PG_ALL
   } prog_kind_t;

   localparam logic [1:0] OPC_EXT   = 2'b00;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_ERASE = 2'b11;

   localparam logic [1:0] SUB_DIS   = 2'b00;
   localparam logic [1:0] SUB_WRALL = 2'b01;
   localparam logic [1:0] SUB_ERALL = 2'b10;
   localparam logic [1:0] SUB_EN    = 2'b11;
endpackage

// File: rtl/sereep_sync.sv
module sereep_sync #(
   parameter int WIDTH  = 3,
   parameter int EDGE_W = 2,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  pin_i,
   output logic [WIDTH-1:0]  lvl_o,
   output logic [EDGE_W-1:0] chg_o
);
   if (STAGES < 2) begin : g_chk_stages
      $error("sereep_sync: STAGES must be at least 2");
   end
   if (EDGE_W < 1 || EDGE_W > WIDTH) begin : g_chk_edge
      $error("sereep_sync: EDGE_W must lie in 1..WIDTH");
   end

   logic [WIDTH-1:0]  chain_q [STAGES];
   logic [EDGE_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= pin_i;
         for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
         prev_q <= chain_q[STAGES-1][EDGE_W-1:0];
      end
   end

   assign lvl_o = chain_q[STAGES-1];
   assign chg_o = chain_q[STAGES-1][EDGE_W-1:0] ^ prev_q;
endmodule

// File: rtl/sereep_ptimer.sv
module sereep_ptimer #(
   parameter int PROG_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic long_i,
   output logic busy_o,
   output logic done_o
);
   if (PROG_CYCLES < 2) begin : g_chk_cycles
      $error("sereep_ptimer: PROG_CYCLES must be at least 2");
   end

   localparam int CW = $clog2(2 * PROG_CYCLES + 1);
   localparam logic [CW-1:0] T_ONE = CW'(PROG_CYCLES);
   localparam logic [CW-1:0] T_TWO = CW'(2 * PROG_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= long_i ? T_TWO : T_ONE;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));

   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/sereep_array.sv
module sereep_array
   import sereep_pkg::*;
#(
   parameter int ADDR_W16 = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W16-1:0] rd_idx_i,
   output logic [WORD_W-1:0]   rd_word_o,
   input  logic                wr_en_i,
   input  logic                wr_all_i,
   input  logic [ADDR_W16-1:0] wr_idx_i,
   input  logic [WORD_W-1:0]   wr_mask_i,
   input  logic [WORD_W-1:0]   wr_data_i
);
   localparam int WORDS = 1 << ADDR_W16;

   logic [WORD_W-1:0] mem_q [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[g] <= '1;
         end else if (wr_en_i && (wr_all_i || wr_idx_i == ADDR_W16'(g))) begin
            mem_q[g] <= (mem_q[g] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
         end
      end
   end

   assign rd_word_o = mem_q[rd_idx_i];
endmodule

// File: rtl/sereep_ctrl.sv
module sereep_ctrl
   import sereep_pkg::*;
#(
   parameter int ADDR_W16 = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wide_i,
   input  logic                cs_lvl_i,
   input  logic                cs_fall_i,
   input  logic                sck_rise_i,
   input  logic                di_i,
   input  logic                busy_i,
   input  logic                done_i,
   input  logic [WORD_W-1:0]   rd_word_i,
   output logic [ADDR_W16-1:0] rd_idx_o,
   output logic                prog_go_o,
   output logic                prog_long_o,
   output logic                wr_en_o,
   output logic                wr_all_o,
   output logic [ADDR_W16-1:0] wr_idx_o,
   output logic [WORD_W-1:0]   wr_mask_o,
   output logic [WORD_W-1:0]   wr_data_o,
   output logic                sdo_o,
   output logic                sdo_oe_o
);
   localparam int AB    = ADDR_W16 + 1;
   localparam int SR_W  = ADDR_W16 + 3;
   localparam int CNT_W = $clog2(SR_W + WORD_W + 1);

   ctl_state_t        state_q;
   prog_kind_t        pend_q;
   logic [SR_W-2:0]   sr_q;
   logic [WORD_W-2:0] dsr_q;
   logic [CNT_W-1:0]  cnt_q, rd_cnt_q;
   logic [AB-1:0]     addr_q;
   logic [WORD_W-1:0] pdata_q, pmask_q, rd_sr_q;
   logic              en_q, status_q, rd_q, rd_bit_q, all_sel_q;
   logic              act_all_q;
   logic [ADDR_W16-1:0] act_idx_q;
   logic [WORD_W-1:0] act_mask_q, act_data_q;

   logic [CNT_W-1:0]  aw_n, need_n, dbits_n, cnt_inc;
   logic [AB-1:0]     amask, dec_addr, look_addr;
   logic [SR_W-1:0]   nxt;
   logic [WORD_W-1:0] dnxt, lane_word;
   logic [1:0]        dec_op, dec_sub;

   function automatic logic [WORD_W-1:0] lane_mask(input logic w, input logic a0);
      if (w) return '1;
      return {{BYTE_W{a0}}, {BYTE_W{~a0}}};
   endfunction

   always_comb begin
      aw_n    = wide_i ? CNT_W'(ADDR_W16) : CNT_W'(ADDR_W16 + 1);
      need_n  = CNT_W'(aw_n + CNT_W'(2));
      dbits_n = wide_i ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
      cnt_inc = CNT_W'(cnt_q + CNT_W'(1));
      amask   = wide_i ? AB'((1 << ADDR_W16) - 1) : '1;
      nxt     = {sr_q, di_i};
      dnxt    = {dsr_q, di_i};
      dec_op  = nxt[aw_n +: 2];
      dec_sub = nxt[CNT_W'(aw_n - CNT_W'(2)) +: 2];
      dec_addr  = nxt[AB-1:0] & amask;
      look_addr = (state_q == ST_CMD) ? dec_addr : (AB'(addr_q + AB'(1)) & amask);
      rd_idx_o  = wide_i ? look_addr[ADDR_W16-1:0] : look_addr[AB-1:1];
      if (wide_i) lane_word = rd_word_i;
      else lane_word = {(look_addr[0] ? rd_word_i[WORD_W-1:BYTE_W] : rd_word_i[BYTE_W-1:0]),
                        {BYTE_W{1'b0}}};
   end

   assign prog_go_o   = cs_fall_i && (state_q == ST_DONE) && (pend_q != PG_NONE) && en_q;
   assign prog_long_o = (pend_q == PG_ALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;  pend_q <= PG_NONE;
         sr_q <= '0;  dsr_q <= '0;  cnt_q <= '0;  rd_cnt_q <= '0;
         addr_q <= '0;  pdata_q <= '0;  pmask_q <= '0;  rd_sr_q <= '0;
         en_q <= 1'b0;  status_q <= 1'b0;  rd_q <= 1'b0;  rd_bit_q <= 1'b0;
         all_sel_q <= 1'b0;
      end else if (cs_fall_i) begin
         state_q <= ST_IDLE;
         rd_q    <= 1'b0;
         pend_q  <= PG_NONE;
         if (prog_go_o) status_q <= 1'b1;
      end else if (cs_lvl_i && sck_rise_i) begin
         case (state_q)
            ST_IDLE: if (di_i && !busy_i) begin
               state_q  <= ST_CMD;
               cnt_q    <= '0;
               sr_q     <= '0;
               status_q <= 1'b0;
               pend_q   <= PG_NONE;
            end
            ST_CMD: begin
               sr_q  <= nxt[SR_W-2:0];
               cnt_q <= cnt_inc;
               if (cnt_inc == need_n) begin
                  addr_q <= dec_addr;
                  cnt_q  <= '0;
                  dsr_q  <= '0;
                  state_q <= ST_DONE;
                  case (dec_op)
                     OPC_READ: begin
                        rd_sr_q  <= lane_word;
                        rd_cnt_q <= dbits_n;
                        rd_bit_q <= 1'b0;
                        rd_q     <= 1'b1;
                        state_q  <= ST_READ;
                     end
                     OPC_WRITE: begin
                        all_sel_q <= 1'b0;
                        state_q   <= ST_DATA;
                     end
                     OPC_ERASE: begin
                        pend_q  <= PG_WORD;
                        pdata_q <= '1;
                        pmask_q <= lane_mask(wide_i, dec_addr[0]);
                     end
                     default: begin
                        case (dec_sub)
                           SUB_EN:    en_q <= 1'b1;
                           SUB_DIS:   en_q <= 1'b0;
                           SUB_ERALL: begin
                              pend_q  <= PG_ALL;
                              pdata_q <= '1;
                              pmask_q <= '1;
                           end
                           default: begin
                              all_sel_q <= 1'b1;
                              state_q   <= ST_DATA;
                           end
                        endcase
                     end
                  endcase
               end
            end
            ST_DATA: begin
               dsr_q <= dnxt[WORD_W-2:0];
               cnt_q <= cnt_inc;
               if (cnt_inc == dbits_n) begin
                  pend_q  <= all_sel_q ? PG_ALL : PG_WORD;
                  pdata_q <= wide_i ? dnxt : {2{dnxt[BYTE_W-1:0]}};
                  pmask_q <= all_sel_q ? '1 : lane_mask(wide_i, addr_q[0]);
                  state_q <= ST_DONE;
               end
            end
            ST_READ: begin
               rd_bit_q <= rd_sr_q[WORD_W-1];
               rd_sr_q  <= rd_sr_q << 1;
               rd_cnt_q <= CNT_W'(rd_cnt_q - CNT_W'(1));
               if (rd_cnt_q == CNT_W'(1)) begin
                  addr_q   <= look_addr;
                  rd_sr_q  <= lane_word;
                  rd_cnt_q <= dbits_n;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_all_q <= 1'b0;  act_idx_q <= '0;  act_mask_q <= '0;  act_data_q <= '0;
      end else if (prog_go_o) begin
         act_all_q  <= (pend_q == PG_ALL);
         act_idx_q  <= wide_i ? addr_q[ADDR_W16-1:0] : addr_q[AB-1:1];
         act_mask_q <= pmask_q;
         act_data_q <= pdata_q;
      end
   end

   assign wr_en_o   = done_i;
   assign wr_all_o  = act_all_q;
   assign wr_idx_o  = act_idx_q;
   assign wr_mask_o = act_mask_q;
   assign wr_data_o = act_data_q;

   assign sdo_o    = rd_q ? rd_bit_q : ~busy_i;
   assign sdo_oe_o = cs_lvl_i & (rd_q | status_q);

   assert_prog_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_i) |-> en_q);
   assert_start_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && state_q == ST_IDLE) |=> state_q == ST_IDLE);
   assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_q) |-> !rd_bit_q);
   assert_release_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall_i |=> !sdo_oe_o);
endmodule

// File: rtl/sereep_model.sv
module sereep_model
   import sereep_pkg::*;
#(
   parameter int ADDR_W16    = 6,
   parameter int PROG_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic org_wide_i,
   input  logic cs_i,
   input  logic sck_i,
   input  logic sdi_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   if (ADDR_W16 < 2 || ADDR_W16 > 10) begin : g_chk_aw
      $error("sereep_model: ADDR_W16 must lie in 2..10");
   end

   logic [2:0] pin_lvl;
   logic [1:0] pin_chg;
   logic       cs_fall, sck_rise, busy, done, prog_go, prog_long;
   logic       wr_en, wr_all;
   logic [ADDR_W16-1:0] rd_idx, wr_idx;
   logic [WORD_W-1:0]   rd_word, wr_mask, wr_data;

   sereep_sync #(.WIDTH(3), .EDGE_W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .pin_i({sdi_i, cs_i, sck_i}),
      .lvl_o(pin_lvl), .chg_o(pin_chg)
   );

   assign sck_rise = pin_chg[0] & pin_lvl[0];
   assign cs_fall  = pin_chg[1] & ~pin_lvl[1];

   sereep_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(prog_go), .long_i(prog_long),
      .busy_o(busy), .done_o(done)
   );

   sereep_array #(.ADDR_W16(ADDR_W16)) u_array (
      .clk(clk), .rst_n(rst_n), .rd_idx_i(rd_idx), .rd_word_o(rd_word),
      .wr_en_i(wr_en), .wr_all_i(wr_all), .wr_idx_i(wr_idx),
      .wr_mask_i(wr_mask), .wr_data_i(wr_data)
   );

   sereep_ctrl #(.ADDR_W16(ADDR_W16)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wide_i(org_wide_i),
      .cs_lvl_i(pin_lvl[1]), .cs_fall_i(cs_fall), .sck_rise_i(sck_rise),
      .di_i(pin_lvl[2]), .busy_i(busy), .done_i(done), .rd_word_i(rd_word),
      .rd_idx_o(rd_idx), .prog_go_o(prog_go), .prog_long_o(prog_long),
      .wr_en_o(wr_en), .wr_all_o(wr_all), .wr_idx_o(wr_idx),
      .wr_mask_o(wr_mask), .wr_data_o(wr_data),
      .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
   );
endmodule

// File: tb/sereep_model_tb.sv
module sereep_model_tb;
   localparam int AW16 = 6;
   localparam int BP   = 1000;
   localparam int HALF = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wide = 1'b1, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
   logic sdo, sdo_oe;
   int   n_chk = 0, n_err = 0, cyc_cnt = 0;
   logic [15:0] rd_buf [4];
   logic        rd_dummy;

   always #4 clk = ~clk;

   sereep_model #(.ADDR_W16(AW16), .PROG_CYCLES(BP)) u_dut (
      .clk(clk), .rst_n(rst_n), .org_wide_i(wide), .cs_i(cs), .sck_i(sck),
      .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
   );

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 190000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_set(input logic v);
      @(negedge clk) cs = v;
      idle(6);
   endtask

   task automatic bclk(input logic b);
      @(negedge clk) sdi = b;
      idle(HALF);
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
      idle(HALF);
   endtask

   task automatic send(input logic [1:0] op, input logic [7:0] a);
      int aw;
      aw = wide ? AW16 : AW16 + 1;
      bclk(1'b1);
      bclk(op[1]);
      bclk(op[0]);
      for (int i = aw - 1; i >= 0; i--) bclk(a[i]);
   endtask

   task automatic send_data(input logic [15:0] d, input int n);
      for (int i = n - 1; i >= 0; i--) bclk(d[i]);
   endtask

   task automatic ext(input logic [1:0] sub);
      int aw;
      aw = wide ? AW16 : AW16 + 1;
      cs_set(1'b1);
      send(2'b00, 8'(sub) << (aw - 2));
      cs_set(1'b0);
   endtask

   task automatic prog_wait(output int cyc);
      @(negedge clk) cs = 1'b0;
      cyc = 0;
      repeat (4) begin @(negedge clk); cyc++; end
      cs = 1'b1;
      while (!(sdo_oe === 1'b1 && sdo === 1'b1) && cyc < 3 * BP + 100) begin
         @(negedge clk); cyc++;
      end
      cs_set(1'b0);
   endtask

   task automatic wr_word(input logic [7:0] a, input logic [15:0] d, output int cyc);
      cs_set(1'b1);
      send(2'b01, a);
      send_data(d, wide ? 16 : 8);
      prog_wait(cyc);
   endtask

   task automatic rd(input logic [7:0] a, input int n);
      logic [15:0] v;
      cs_set(1'b1);
      send(2'b10, a);
      rd_dummy = sdo;
      for (int w = 0; w < n; w++) begin
         v = '0;
         for (int b = 0; b < (wide ? 16 : 8); b++) begin
            bclk(1'b0);
            v = {v[14:0], sdo};
         end
         rd_buf[w] = v;
      end
      cs_set(1'b0);
   endtask

   task automatic t_reset;
      chk("R10", "oe after reset", sdo_oe, 1'b0);
   endtask

   task automatic t_protect;
      cs_set(1'b1);
      send(2'b01, 8'd5);
      send_data(16'hA5C3, 16);
      cs_set(1'b0);
      cs_set(1'b1);
      chk("R5", "no status when disabled", sdo_oe, 1'b0);
      cs_set(1'b0);
      rd(8'd5, 1);
      chk("R5", "word 5 untouched while disabled", rd_buf[0], 16'hFFFF);
      chk("R3", "dummy bit", rd_dummy, 1'b0);
   endtask

   task automatic t_write;
      int c;
      ext(2'b11);
      wr_word(8'd5, 16'hA5C3, c);
      chk_rng("R11", "single program time", c, BP, BP + 10);
      rd(8'd5, 1);
      chk("R7", "write word 5", rd_buf[0], 16'hA5C3);
      chk("R6", "enable took effect", rd_buf[0], 16'hA5C3);
      chk("R3", "dummy bit before data", rd_dummy, 1'b0);
   endtask

   task automatic t_start;
      logic [15:0] v;
      cs_set(1'b0);
      bclk(1'b1);
      bclk(1'b1);
      cs_set(1'b1);
      chk("R1", "clocks with select low ignored", sdo_oe, 1'b0);
      for (int i = 0; i < 3; i++) bclk(1'b0);
      chk("R1", "leading zeros no command", sdo_oe, 1'b0);
      send(2'b10, 8'd5);
      v = '0;
      for (int b = 0; b < 16; b++) begin bclk(1'b0); v = {v[14:0], sdo}; end
      chk("R1", "read after leading zeros", v, 16'hA5C3);
      cs_set(1'b0);
   endtask

   task automatic t_seq;
      int c;
      wr_word(8'd6, 16'h1234, c);
      wr_word(8'd63, 16'hBEEF, c);
      wr_word(8'd0, 16'h0F0F, c);
      rd(8'd5, 2);
      chk("R4", "seq first", rd_buf[0], 16'hA5C3);
      chk("R4", "seq second", rd_buf[1], 16'h1234);
      rd(8'd63, 2);
      chk("R4", "last word", rd_buf[0], 16'hBEEF);
      chk("R4", "wrap to 0", rd_buf[1], 16'h0F0F);
   endtask

   task automatic t_erase;
      int c;
      cs_set(1'b1);
      send(2'b11, 8'd6);
      prog_wait(c);
      rd(8'd5, 2);
      chk("R7", "neighbour kept", rd_buf[0], 16'hA5C3);
      chk("R7", "erased word", rd_buf[1], 16'hFFFF);
   endtask

   task automatic t_partial;
      cs_set(1'b1);
      send(2'b01, 8'd5);
      send_data(16'h0000, 15);
      cs_set(1'b0);
      cs_set(1'b1);
      chk("R9", "no cycle after short command", sdo_oe, 1'b0);
      cs_set(1'b0);
      rd(8'd5, 1);
      chk("R9", "word unchanged", rd_buf[0], 16'hA5C3);
   endtask

   task automatic t_busy;
      int c;
      logic [15:0] v;
      cs_set(1'b1);
      send(2'b01, 8'd6);
      send_data(16'hC3C3, 16);
      cs_set(1'b0);
      cs_set(1'b1);
      chk("R10", "busy drives oe", sdo_oe, 1'b1);
      chk("R10", "busy value", sdo, 1'b0);
      send(2'b10, 8'd5);
      v = '0;
      for (int b = 0; b < 16; b++) begin bclk(1'b0); v = {v[14:0], sdo}; end
      chk("R11", "start ignored while busy", v, 16'h0000);
      cs_set(1'b0);
      chk("R10", "undriven with select low", sdo_oe, 1'b0);
      @(negedge clk) cs = 1'b1;
      c = 0;
      while (!(sdo_oe === 1'b1 && sdo === 1'b1) && c < 3 * BP) begin @(negedge clk); c++; end
      chk("R10", "ready value", sdo, 1'b1);
      cs_set(1'b0);
      rd(8'd6, 1);
      chk("R7", "write after busy", rd_buf[0], 16'hC3C3);
   endtask

   task automatic t_ewds;
      ext(2'b00);
      cs_set(1'b1);
      send(2'b01, 8'd6);
      send_data(16'h0000, 16);
      cs_set(1'b0);
      rd(8'd6, 1);
      chk("R6", "disabled write ignored", rd_buf[0], 16'hC3C3);
      ext(2'b11);
   endtask

   task automatic t_x8;
      int c;
      wide = 1'b0;
      idle(4);
      rd(8'd10, 2);
      chk("R2", "byte 10 low lane", rd_buf[0], 16'h00C3);
      chk("R2", "byte 11 high lane", rd_buf[1], 16'h00A5);
      wr_word(8'd13, 16'h005A, c);
      wide = 1'b1;
      idle(4);
      rd(8'd6, 1);
      chk("R2", "byte write lane", rd_buf[0], 16'h5AC3);
   endtask

   task automatic t_coincide;
      cs_set(1'b1);
      send(2'b01, 8'd7);
      send_data(16'h1111, 15);
      @(negedge clk) sdi = 1'b1;
      idle(HALF);
      cs = 1'b0;
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
      idle(HALF);
      cs_set(1'b1);
      chk("R12", "no cycle on coincident edge", sdo_oe, 1'b0);
      cs_set(1'b0);
      rd(8'd7, 1);
      chk("R12", "word 7 unchanged", rd_buf[0], 16'hFFFF);
   endtask

   task automatic t_all;
      int c;
      cs_set(1'b1);
      send(2'b00, 8'b10_0000);
      prog_wait(c);
      chk_rng("R11", "erase-all time", c, 2 * BP, 2 * BP + 10);
      rd(8'd5, 2);
      chk("R8", "erase-all word 5", rd_buf[0], 16'hFFFF);
      chk("R8", "erase-all word 6", rd_buf[1], 16'hFFFF);
      cs_set(1'b1);
      send(2'b00, 8'b01_0000);
      send_data(16'h3C96, 16);
      prog_wait(c);
      chk_rng("R11", "write-all time", c, 2 * BP, 2 * BP + 10);
      rd(8'd63, 2);
      chk("R8", "write-all word 63", rd_buf[0], 16'h3C96);
      chk("R8", "write-all word 0", rd_buf[1], 16'h3C96);
      rd(8'd33, 1);
      chk("R8", "write-all word 33", rd_buf[0], 16'h3C96);
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_protect();
      t_write();
      t_start();
      t_seq();
      t_erase();
      t_partial();
      t_busy();
      t_ewds();
      t_x8();
      t_coincide();
      t_all();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule